// File: doc/BRIEF.md
# Event Word Packer with Suppression

This block turns the digitized results of one detector card into a stream of 32-bit event words. A one-cycle start pulse from the trigger path begins a scan. The scan visits every ADC channel in turn, from index 0 upward, and handles one channel per clock. For each channel it builds a word from the channel's 16-bit result, its 5-bit channel index and its two pileup qualifier bits. Each word that survives the optional filters goes into an internal FIFO, and a downstream reader drains that FIFO through a simple read strobe.

There are two filters, each with its own enable. The first drops channels whose result is zero. The second drops channels whose result falls outside an inclusive window set by a low bound and a high bound. Every kept word carries its channel index, so the reader can tell where each word came from after filtering.

When the FIFO is full, the scan stops on the pending channel and waits until space opens, so no word is lost. A sticky flag records that a wait happened. A done flag goes high once every channel has been handled and the last kept word is in the FIFO. A separate diagnostic port returns the raw result of any single channel chosen by index. The channel results and qualifiers must be held stable from the start pulse until done.

Top module: `evpack_top`

## Requirements
- R1: Each stored word is laid out as follows: qualifier bits in [31:30], zeros in [29:21], channel index in [20:16], and the 16-bit channel result in [15:0].
- R2: With both filters off, a scan stores one word per channel in ascending index order, 20 words in total.
- R3: When the empty filter is enabled, a channel whose result is 0 is not stored. When the filter is disabled, a zero result is stored like any other value.
- R4: When the window filter is enabled, a channel is stored only if winLo <= result <= winHi. Both bounds are inclusive.
- R5: When the FIFO (depth 16) is full, the scan holds the pending channel until space appears, and no word is lost or reordered. The overflow flag goes high only if a kept word meets a full FIFO. It stays low on a scan that fills the FIFO exactly, and it clears on the next accepted start.
- R6: Done goes high exactly NUM_CH clock edges after the edge that accepts the start, provided no stall occurs. It stays high until the next start, which clears it on the accepting edge. A start pulse that arrives during a scan is ignored.
- R7: diagData shows the result of channel diagIdx one clock edge after diagIdx is applied. An index of NUM_CH or above returns 0.
- R8: rdData always shows the oldest stored word. A read strobe removes that word at the clock edge. A read strobe while fifoEmpty is 1 has no effect.
- R9: After reset, fifoEmpty is 1, and done, overflow and diagData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Readout request pulse |
| supEmpty | input | 1 | Enable the filter for zero results |
| supWindow | input | 1 | Enable the window filter |
| winLo | input | 16 | Window low bound (inclusive) |
| winHi | input | 16 | Window high bound (inclusive) |
| adcFlat | input | 320 | Channel results; channel i occupies bits [16i+15:16i] |
| qualFlat | input | 40 | Qualifier pairs; channel i occupies bits [2i+1:2i] |
| rdEn | input | 1 | Read strobe: remove the head word |
| rdData | output | 32 | Head word of the FIFO |
| fifoEmpty | output | 1 | FIFO holds no words |
| done | output | 1 | Scan complete |
| overflow | output | 1 | A kept word had to wait for a full FIFO |
| diagIdx | input | 5 | Diagnostic channel select |
| diagData | output | 16 | Diagnostic channel result |

## Verification
A start sampled at edge P0 puts channel k in the filter on edge P(k+1). Its word shows at rdData one edge later, and done rises after edge P20. The bench checks that done is 0 after P19 and 1 after P20, with all samples taken at falling edges. The diagnostic result is checked one edge after the index changes. The stall test leaves the FIFO unread for 40 cycles and then drains it, checking that the overflow flag is set and that the word sequence is complete. Expected word lists come from a model of the window and empty rules that is written separately in the bench.

// File: rtl/evpack_pkg.sv
package evpack_pkg;
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic wrEn;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scanState_t;
endpackage

// File: rtl/evpack_fifo.sv
module evpack_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              push, pop;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign push  = wrEn && !full;
  assign pop   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R5: the scanner must never present a write to a full FIFO
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !full);

  // R8: a read strobe on an empty FIFO with no write leaves it empty
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && empty && !wrEn) |=> empty);
endmodule

// File: rtl/evpack_datapath.sv
module evpack_datapath
  import evpack_pkg::*;
#(
  parameter int NUM_CH     = 20,
  parameter int DATA_W     = 16,
  parameter int QUAL_W     = 2,
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int IDX_W      = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic                     supEmpty,
  input  logic                     supWindow,
  input  logic [DATA_W-1:0]        winLo,
  input  logic [DATA_W-1:0]        winHi,
  input  logic [NUM_CH*DATA_W-1:0] adcFlat,
  input  logic [NUM_CH*QUAL_W-1:0] qualFlat,
  input  logic                     rdEn,
  output logic [WORD_W-1:0]        rdData,
  output logic                     fifoEmpty,
  output logic                     keep,
  output logic                     fifoFull,
  output logic                     lastCh,
  input  logic [IDX_W-1:0]         diagIdx,
  output logic [DATA_W-1:0]        diagData
);
  localparam int PAD_W = WORD_W - QUAL_W - IDX_W - DATA_W;

  logic [DATA_W-1:0] chVal  [NUM_CH];
  logic [QUAL_W-1:0] chQual [NUM_CH];
  logic [IDX_W-1:0]  chIdx;
  logic [DATA_W-1:0] curVal;
  logic [QUAL_W-1:0] curQual;
  logic [WORD_W-1:0] curWord;
  logic              isEmpty, outWindow;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign chVal[g]  = adcFlat[g*DATA_W +: DATA_W];
    assign chQual[g] = qualFlat[g*QUAL_W +: QUAL_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                chIdx <= '0;
    else if (strobes.clrIdx)  chIdx <= '0;
    else if (strobes.incIdx)  chIdx <= chIdx + IDX_W'(1);
  end

  always_comb begin
    curVal  = '0;
    curQual = '0;
    if (int'(chIdx) < NUM_CH) begin
      curVal  = chVal[chIdx];
      curQual = chQual[chIdx];
    end
  end

  assign lastCh    = (chIdx == IDX_W'(NUM_CH - 1));
  assign isEmpty   = (curVal == '0);
  assign outWindow = (curVal < winLo) || (curVal > winHi);
  assign keep      = !(supEmpty && isEmpty) && !(supWindow && outWindow);
  assign curWord   = {curQual, {PAD_W{1'b0}}, chIdx, curVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) diagData <= '0;
    else if (int'(diagIdx) < NUM_CH) diagData <= chVal[diagIdx];
    else diagData <= '0;
  end

  evpack_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobes.wrEn),
    .wrData (curWord),
    .rdEn   (rdEn),
    .rdData (rdData),
    .full   (fifoFull),
    .empty  (fifoEmpty)
  );

  // R2: the channel index advances by exactly one per step
  assert_scan_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incIdx && !strobes.clrIdx) |=> chIdx == $past(chIdx) + IDX_W'(1));

  // R3 / R4: only words that pass the filters are written
  assert_write_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> keep);
endmodule

// File: rtl/evpack_ctrl.sv
module evpack_ctrl
  import evpack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         keep,
  input  logic         fifoFull,
  input  logic         lastCh,
  output ctrlStrobes_t strobes,
  output logic         done,
  output logic         overflow
);
  scanState_t state, nextState;
  logic       adv;
  logic       accept;

  always_comb begin
    strobes   = '0;
    nextState = state;
    adv       = 1'b0;
    accept    = 1'b0;
    case (state)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          accept         = 1'b1;
          strobes.clrIdx = 1'b1;
          nextState      = ST_SCAN;
        end
      end
      ST_SCAN: begin
        adv          = !keep || !fifoFull;
        strobes.wrEn = keep && !fifoFull;
        if (adv) begin
          if (lastCh) nextState = ST_FIN;
          else        strobes.incIdx = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      overflow <= 1'b0;
    end else begin
      state <= nextState;
      if (accept)                                   overflow <= 1'b0;
      else if (state == ST_SCAN && keep && fifoFull) overflow <= 1'b1;
    end
  end

  assign done = (state == ST_FIN);

  // R6: done holds until a new start arrives
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R5: the overflow flag is sticky within a scan
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !start) |=> overflow);

  // R6: a start pulse during a scan does not restart it
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && start && !strobes.incIdx && !lastCh) |=> !strobes.clrIdx || state != ST_SCAN);
endmodule

// File: rtl/evpack_top.sv
module evpack_top
  import evpack_pkg::*;
#(
  parameter int NUM_CH     = 20,
  parameter int DATA_W     = 16,
  parameter int QUAL_W     = 2,
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int IDX_W      = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     supEmpty,
  input  logic                     supWindow,
  input  logic [DATA_W-1:0]        winLo,
  input  logic [DATA_W-1:0]        winHi,
  input  logic [NUM_CH*DATA_W-1:0] adcFlat,
  input  logic [NUM_CH*QUAL_W-1:0] qualFlat,
  input  logic                     rdEn,
  output logic [WORD_W-1:0]        rdData,
  output logic                     fifoEmpty,
  output logic                     done,
  output logic                     overflow,
  input  logic [IDX_W-1:0]         diagIdx,
  output logic [DATA_W-1:0]        diagData
);
  ctrlStrobes_t strobes;
  logic         keep, fifoFull, lastCh;

  evpack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .keep     (keep),
    .fifoFull (fifoFull),
    .lastCh   (lastCh),
    .strobes  (strobes),
    .done     (done),
    .overflow (overflow)
  );

  evpack_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .QUAL_W(QUAL_W),
    .WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .supEmpty  (supEmpty),
    .supWindow (supWindow),
    .winLo     (winLo),
    .winHi     (winHi),
    .adcFlat   (adcFlat),
    .qualFlat  (qualFlat),
    .rdEn      (rdEn),
    .rdData    (rdData),
    .fifoEmpty (fifoEmpty),
    .keep      (keep),
    .fifoFull  (fifoFull),
    .lastCh    (lastCh),
    .diagIdx   (diagIdx),
    .diagData  (diagData)
  );
endmodule

// File: tb/evpack_top_test.sv
module evpack_top_test;
  localparam int NCH = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        supEmpty = 1'b0, supWindow = 1'b0;
  logic [15:0] winLo = '0, winHi = '0;
  logic [NCH*16-1:0] adcFlat;
  logic [NCH*2-1:0]  qualFlat;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        fifoEmpty, done, overflow;
  logic [4:0]  diagIdx = '0;
  logic [15:0] diagData;

  logic [15:0] vals  [NCH];
  logic [1:0]  quals [NCH];
  logic [31:0] got   [64];
  int          nGot;
  int          testsRun = 0, testsFailed = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      adcFlat[i*16 +: 16] = vals[i];
      qualFlat[i*2 +: 2]  = quals[i];
    end
  end

  evpack_top uut (
    .clk(clk), .rstN(rstN), .start(start), .supEmpty(supEmpty),
    .supWindow(supWindow), .winLo(winLo), .winHi(winHi),
    .adcFlat(adcFlat), .qualFlat(qualFlat), .rdEn(rdEn),
    .rdData(rdData), .fifoEmpty(fifoEmpty), .done(done),
    .overflow(overflow), .diagIdx(diagIdx), .diagData(diagData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // drain until done and empty; optional extra start pulse at cycle midStart
  task automatic collect(input int midStart);
    int cyc = 0;
    nGot = 0;
    while (!(done && fifoEmpty) && cyc < 500) begin
      @(negedge clk);
      start = (cyc == midStart);
      if (!fifoEmpty && nGot < 64) begin
        got[nGot] = rdData; nGot++; rdEn = 1'b1;
      end else rdEn = 1'b0;
      cyc++;
    end
    @(negedge clk); rdEn = 1'b0; start = 1'b0;
  endtask

  task automatic compareWords(input string req);
    int k = 0;
    for (int i = 0; i < NCH; i++) begin
      bit kp = 1;
      if (supEmpty && vals[i] == 0) kp = 0;
      if (supWindow && (vals[i] < winLo || vals[i] > winHi)) kp = 0;
      if (kp) begin
        logic [31:0] exp = {quals[i], 9'b0, 5'(i), vals[i]};
        if (k < nGot) check(got[k] == exp, req, got[k], exp);
        k++;
      end
    end
    check(nGot == k, {req, " count"}, nGot, k);
  endtask

  task automatic fillVals();
    for (int i = 0; i < NCH; i++) begin
      vals[i]  = 16'(1000 + 37 * i);
      quals[i] = 2'(i % 4);
    end
  endtask

  task automatic testReset();
    check(fifoEmpty == 1, "R9 empty", fifoEmpty, 1);
    check(done == 0, "R9 done", done, 0);
    check(overflow == 0, "R9 overflow", overflow, 0);
    check(diagData == 0, "R9 diag", diagData, 0);
  endtask

  task automatic testStallAll();
    fillVals(); supEmpty = 0; supWindow = 0;
    pulseStart();
    repeat (40) @(negedge clk);
    check(overflow == 1, "R5 overflow set", overflow, 1);
    check(done == 0, "R5 stalled not done", done, 0);
    collect(-1);
    compareWords("R2 R1 R5 all channels");
    check(done == 1, "R6 done after drain", done, 1);
  endtask

  task automatic testEmptySuppressTiming();
    fillVals();
    for (int i = 0; i < 6; i++) vals[i*3] = 16'd0;
    supEmpty = 1; supWindow = 0;
    pulseStart();
    check(done == 0, "R6 done cleared by start", done, 0);
    check(overflow == 0, "R5 overflow cleared by start", overflow, 0);
    repeat (19) @(negedge clk);
    check(done == 0, "R6 done not early", done, 0);
    @(negedge clk);
    check(done == 1, "R6 done on time", done, 1);
    check(overflow == 0, "R5 no overflow", overflow, 0);
    collect(-1);
    compareWords("R3 empty dropped");
  endtask

  task automatic testZeroKeptWhenOff();
    fillVals();
    vals[2] = 16'd0; vals[9] = 16'd0; vals[5] = 16'd50;
    supEmpty = 0; supWindow = 1; winLo = 16'd0; winHi = 16'd100;
    pulseStart(); collect(-1);
    compareWords("R3 zero kept when filter off");
    check(nGot == 3, "R3 zero count", nGot, 3);
  endtask

  task automatic testWindowBounds();
    fillVals();
    vals[1] = 16'd99; vals[2] = 16'd100; vals[3] = 16'd200;
    vals[4] = 16'd201; vals[7] = 16'd150; vals[8] = 16'd0;
    supEmpty = 0; supWindow = 1; winLo = 16'd100; winHi = 16'd200;
    pulseStart(); collect(-1);
    compareWords("R4 window inclusive");
    check(nGot == 3, "R4 window count", nGot, 3);
  endtask

  task automatic testExactFill();
    fillVals();
    for (int i = 0; i < 4; i++) vals[i*5 + 1] = 16'd0;
    supEmpty = 1; supWindow = 0;
    pulseStart();
    repeat (30) @(negedge clk);
    check(done == 1, "R5 exact fill done", done, 1);
    check(overflow == 0, "R5 exact fill no overflow", overflow, 0);
    collect(-1);
    compareWords("R5 exact fill words");
  endtask

  task automatic testStartDuringScan();
    fillVals();
    for (int i = 0; i < 6; i++) vals[i] = 16'd0;
    supEmpty = 1; supWindow = 0;
    pulseStart(); collect(5);
    compareWords("R6 restart ignored");
  endtask

  task automatic testDiag();
    fillVals();
    @(negedge clk); diagIdx = 5'd7;
    @(negedge clk);
    check(diagData == vals[7], "R7 diag read", diagData, vals[7]);
    diagIdx = 5'd19;
    @(negedge clk);
    check(diagData == vals[19], "R7 diag last", diagData, vals[19]);
    diagIdx = 5'd25;
    @(negedge clk);
    check(diagData == 0, "R7 diag out of range", diagData, 0);
  endtask

  task automatic testReadEmpty();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    check(fifoEmpty == 1, "R8 read on empty", fifoEmpty, 1);
    fillVals(); supEmpty = 0; supWindow = 1; winLo = 16'd1000; winHi = 16'd1111;
    pulseStart(); collect(-1);
    compareWords("R8 head order after empty read");
  endtask

  initial begin
    fillVals();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testStallAll();
    testEmptySuppressTiming();
    testZeroKeptWhenOff();
    testWindowBounds();
    testExactFill();
    testStartDuringScan();
    testDiag();
    testReadEmpty();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule